// File: doc/BRIEF.md
# Strobed Byte Receive Port

This block is a receive-only port that accepts bytes from an external producer and hands them to a bus host. The producer drives a byte and marks it with a rising edge on its own strobe line. That strobe has no relation to the system clock. The rising edge latches the byte into a small register in the strobe domain. A multi-stage synchroniser then turns the edge into a single-cycle pulse in the system clock domain. On that pulse the byte moves into a holding register and a ready flag is set.

The host has two ways to learn that a byte is waiting. It can poll a status register, or it can enable an interrupt. A host read of the data register takes the byte and clears the ready flag as a side effect. While the ready flag is set, the port also drives a request line towards a DMA engine. If a second byte arrives before the host has read the first, a sticky overrun bit records the loss and the newer byte replaces the older one. A read of the status register clears the overrun bit.

Top module: `byte_rx_port`

## Requirements
- R1: When reset is released, the ready flag (status bit 7), the overrun flag (status bit 6), the interrupt enable (control bit 0), `irq` and `dma_req` are all 0. The status register reads 0x00.
- R2: A rising edge of `dev_stb` captures `dev_data`. Within SYNC_STAGES+2 system clock cycles, the byte reads back from the data register (address 0) and the ready flag (status register at address 1, bit 7) is set.
- R3: A bus read of the data register clears the ready flag at the end of that bus cycle, unless a new byte is captured in that same cycle.
- R4: A capture while the ready flag is already set sets the overrun flag (status bit 6). The newest byte replaces the held byte.
- R5: A bus read of the status register clears the overrun flag at the end of that bus cycle. The ready flag is left unchanged.
- R6: The control register (address 2) holds the interrupt enable in bit 0 and reads it back. The other control bits read 0.
- R7: `irq` equals the ready flag ANDed with the interrupt enable.
- R8: `dma_req` is high exactly while the ready flag is set.
- R9: Bus writes to addresses 0, 1 and 3 have no effect, because the port has no host-to-device path. Status bits 5 to 0 read 0, address 3 reads 0x00, and `bus_rdata` is 0 when `bus_sel` is low.
- R10: Each rising strobe edge yields exactly one capture. A strobe held high yields no further bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| dev_stb | input | 1 | Producer strobe; the rising edge marks a valid byte |
| dev_data | input | DATA_W | Producer byte, stable around the strobe's rising edge |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Interrupt: byte ready and interrupt enabled |
| dma_req | output | 1 | DMA request while a byte is held |

## Verification
The bench sends bytes back to back without reading them. This checks that overrun is flagged, that the newest byte is kept, and that a status read clears only overrun. A design that dropped the overrun bit, or kept the stale byte, would fail those reads. It also holds the strobe high across a data read, which catches a design that detects the level instead of the edge: such a design would set ready again. Writes to the data and status addresses are checked for having no effect, which catches a decoder that let a host write corrupt the flags. Random interleaving of captures, reads and enable changes shows whether `irq` or `dma_req` ever fall out of step with the ready flag.

// File: rtl/byte_rx_pkg.sv
package byte_rx_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int IE_POS = 0;

  typedef struct packed {
    logic ready;
    logic ovr;
  } rx_flags_t;

endpackage

// File: rtl/byte_rx_rst_sync.sv
module byte_rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/byte_rx_strobe_sync.sv
module byte_rx_strobe_sync #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_stb,
  input  logic [DATA_W-1:0] dev_data,
  output logic              cap_pulse,
  output logic [DATA_W-1:0] cap_data
);

  localparam int CHAIN = SYNC_STAGES + 1;

  // Producer domain: byte latched on the strobe's own edge.
  logic [DATA_W-1:0] stb_byte_q;

  always_ff @(posedge dev_stb) begin
    stb_byte_q <= dev_data;
  end

  // System domain: strobe level through the synchroniser plus one edge flop.
  logic [CHAIN-1:0] sync_q;
  logic [CHAIN-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[CHAIN-2:0], dev_stb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign cap_pulse = sync_q[CHAIN-2] & ~sync_q[CHAIN-1];
  assign cap_data  = stb_byte_q;

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);

endmodule

// File: rtl/byte_rx_flags.sv
module byte_rx_flags
  import byte_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pulse,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd_data,
  input  logic              rd_stat,
  output rx_flags_t         flags,
  output logic [DATA_W-1:0] hold_byte
);

  rx_flags_t         flags_q, flags_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_en;

  always_comb begin
    flags_d = flags_q;
    if (rd_data)   flags_d.ready = 1'b0;
    if (cap_pulse) flags_d.ready = 1'b1;
    if (rd_stat)   flags_d.ovr   = 1'b0;
    if (cap_pulse && flags_q.ready && !rd_data) flags_d.ovr = 1'b1;
  end

  assign hold_en = cap_pulse;
  assign hold_d  = cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign flags     = flags_q;
  assign hold_byte = hold_q;

  // R2
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.ready) |-> $past(cap_pulse));

  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !cap_pulse) |=> !flags_q.ready);

  // R4
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.ovr) |-> $past(cap_pulse && flags_q.ready));

  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !cap_pulse) |=> !flags_q.ovr);

  // R5
  stat_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rd_data && !cap_pulse) |=> $stable(flags_q.ready));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |=> $stable(hold_q));

endmodule

// File: rtl/byte_rx_regs.sv
module byte_rx_regs
  import byte_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  rx_flags_t         flags,
  input  logic [DATA_W-1:0] hold_byte,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rd_data,
  output logic              rd_stat,
  output logic              ie
);

  localparam int RDY_POS = DATA_W - 1;
  localparam int OVR_POS = DATA_W - 2;

  reg_sel_e sel;
  logic     rd_cyc, wr_cyc;
  logic     ie_q, ie_d, ie_en;

  assign sel    = reg_sel_e'(bus_addr);
  assign rd_cyc = bus_sel & ~bus_wr;
  assign wr_cyc = bus_sel &  bus_wr;

  assign rd_data = rd_cyc && (sel == SEL_DATA);
  assign rd_stat = rd_cyc && (sel == SEL_STAT);

  assign ie_en = wr_cyc && (sel == SEL_CTRL);
  assign ie_d  = bus_wdata[IE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_en) ie_q <= ie_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (sel)
        SEL_DATA: bus_rdata = hold_byte;
        SEL_STAT: begin
          bus_rdata[RDY_POS] = flags.ready;
          bus_rdata[OVR_POS] = flags.ovr;
        end
        SEL_CTRL: bus_rdata[IE_POS] = ie_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign ie = ie_q;

  // R6
  ie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_en |=> $stable(ie_q));

endmodule

// File: rtl/byte_rx_port.sv
module byte_rx_port
  import byte_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_stb,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              dma_req
);

  logic              rst_n_int;
  logic              cap_pulse;
  logic [DATA_W-1:0] cap_data;
  logic              rd_data, rd_stat, ie;
  rx_flags_t         flags;
  logic [DATA_W-1:0] hold_byte;

  byte_rx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  byte_rx_strobe_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .dev_stb   (dev_stb),
    .dev_data  (dev_data),
    .cap_pulse (cap_pulse),
    .cap_data  (cap_data)
  );

  byte_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap_pulse (cap_pulse),
    .cap_data  (cap_data),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .flags     (flags),
    .hold_byte (hold_byte)
  );

  byte_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags),
    .hold_byte (hold_byte),
    .bus_rdata (bus_rdata),
    .rd_data   (rd_data),
    .rd_stat   (rd_stat),
    .ie        (ie)
  );

  assign irq     = flags.ready & ie;
  assign dma_req = flags.ready;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq |-> dma_req);

  // R8
  dma_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dma_req && rd_data && !cap_pulse) |=> !dma_req);

endmodule

// File: tb/tb_byte_rx_port.sv
module tb_byte_rx_port;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dev_stb;
  logic [DATA_W-1:0] dev_data;
  logic              bus_sel, bus_wr;
  logic [1:0]        bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq, dma_req;

  int n_checks = 0;
  int n_errors = 0;

  // bench model
  logic       m_ready, m_ovr, m_ie;
  logic [7:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_rx_port dut (
    .clk(clk), .rst_n(rst_n), .dev_stb(dev_stb), .dev_data(dev_data),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  function automatic logic [7:0] exp_status(input logic r, input logic o);
    return {r, o, 6'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_wt(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // strobe edge, held high 4 cycles, low 3 cycles: capture is complete on return
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    dev_data = b;
    #2 dev_stb = 1'b1;
    repeat (4) @(negedge clk);
    dev_stb = 1'b0;
    repeat (3) @(negedge clk);
    if (m_ready) m_ovr = 1'b1;
    m_ready = 1'b1;
    m_data  = b;
  endtask

  task automatic check_lines(input string req);
    #1;
    check(dma_req === m_ready, {req, " R8 dma_req"}, dma_req, m_ready);
    check(irq === (m_ready & m_ie), {req, " R7 irq"}, irq, m_ready & m_ie);
  endtask

  task automatic rd_stat_chk(input string req);
    logic [7:0] d;
    bus_rd(2'd1, d);
    check(d === exp_status(m_ready, m_ovr), req, d, exp_status(m_ready, m_ovr));
    m_ovr = 1'b0;
  endtask

  task automatic rd_data_chk(input string req);
    logic [7:0] d;
    bus_rd(2'd0, d);
    check(d === m_data, req, d, m_data);
    m_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] d;
    void'($urandom(32'd2024));
    rst_n = 1'b0; dev_stb = 1'b0; dev_data = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_ready = 1'b0; m_ovr = 1'b0; m_ie = 1'b0; m_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(irq === 1'b0, "R1 irq", irq, 0);
    check(dma_req === 1'b0, "R1 dma_req", dma_req, 0);
    rd_stat_chk("R1 status");
    bus_rd(2'd2, d);
    check(d === 8'h00, "R1 control", d, 0);
    bus_rd(2'd3, d);
    check(d === 8'h00, "R9 addr3 reads zero", d, 0);
    #1 check(bus_rdata === 8'h00, "R9 idle rdata", bus_rdata, 0);

    // R2 capture within SYNC_STAGES+2 cycles
    @(negedge clk);
    dev_data = 8'hA5;
    #2 dev_stb = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(dma_req === 1'b1, "R2 ready within sync latency", dma_req, 1);
    dev_stb = 1'b0;
    repeat (2) @(negedge clk);
    m_ready = 1'b1; m_data = 8'hA5;
    rd_stat_chk("R2 status ready");
    check_lines("R2");
    rd_data_chk("R2 data");
    check_lines("R3 after data read");
    rd_stat_chk("R3 ready cleared");

    // R6 / R7 control and irq
    bus_wt(2'd2, 8'hFF); m_ie = 1'b1;
    bus_rd(2'd2, d);
    check(d === 8'h01, "R6 ctrl readback", d, 8'h01);
    send_byte(8'h3C);
    check_lines("R7 irq with ie");
    bus_wt(2'd2, 8'h00); m_ie = 1'b0;
    check_lines("R7 irq masked");

    // R9 writes to data/status/addr3 ignored
    bus_wt(2'd0, 8'h00);
    bus_wt(2'd1, 8'h00);
    bus_wt(2'd3, 8'hFF);
    check_lines("R9 after writes");
    rd_stat_chk("R9 status untouched");
    bus_rd(2'd2, d);
    check(d === 8'h00, "R9 ctrl untouched by addr3", d, 0);

    // R4 overrun, newest wins; R5 status read clears overrun only
    send_byte(8'hC3);
    rd_stat_chk("R4 overrun set");
    rd_stat_chk("R5 overrun cleared, ready kept");
    rd_data_chk("R4 newest byte kept");
    check_lines("R4");

    // R10 strobe held high across a data read
    @(negedge clk);
    dev_data = 8'h5A;
    #2 dev_stb = 1'b1;
    repeat (5) @(negedge clk);
    m_ready = 1'b1; m_data = 8'h5A;
    rd_data_chk("R10 held-strobe byte");
    repeat (10) @(negedge clk);
    check_lines("R10 no repeat capture");
    rd_stat_chk("R10 status");
    dev_stb = 1'b0;
    repeat (3) @(negedge clk);

    // random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom % 5)
        0, 1: send_byte(8'($urandom));
        2: rd_data_chk("R3 random data read");
        3: rd_stat_chk("R5 random status read");
        default: begin
          d = 8'($urandom);
          bus_wt(2'd2, d);
          m_ie = d[0];
        end
      endcase
      check_lines("R7/R8 random");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule